// File: doc/BRIEF.md
# Serial PHY management master

This block is the master side of the two-wire management bus that a MAC uses to reach the 16-bit registers of an external Ethernet PHY. It produces the management clock (MDC) from the system clock through an 8-bit divisor. It shifts out the serial management frames MSB first and reads the data the PHY returns. The bidirectional data line is split into a data input (`mdi`), a data output (`mdo`) and an output enable (`mdo_oe`). The pad that joins them sits outside the block.

A host asks for one of three operations. A one-shot write sends `wr_data` to a PHY register. A one-shot read fetches a register. A scan is a level request: while it is held, the block polls the same register back to back. When a one-shot operation is accepted, the block raises a one-cycle start pulse so the host can drop its request bit. Each completed read or scan frame delivers 16 bits with a one-cycle update strobe. The block also reports a busy flag, a not-valid flag for scan data and a link-fail flag taken from the returned data.

Top module: `mdio_master`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs settle to `mdc`=0, `mdo_oe`=0, `busy`=0, `not_valid`=1, `link_fail`=0, `rd_data`=0, `rd_update`=0 and both start pulses 0.
- R2: `mdc` is a square wave with a period of 2*max(floor(`clk_div`/2),1) system clocks.
- R3: A frame is 32 ones, then start 01, then opcode (read 10, write 01), then the 5-bit PHY address, the 5-bit register address, a 2-bit turnaround and 16 data bits, all MSB first. `mdo` and `mdo_oe` change only on the clock edge at which `mdc` falls.
- R4: With `no_preamble`=1 the 32 ones are left out and the frame begins with the start bits, so it has 32 bit times instead of 64.
- R5: In a read, `mdo_oe` is 0 for both turnaround bits and all 16 data bits. `mdi` is sampled at each rising `mdc` edge of the data phase. After the last data bit, `rd_data` holds the 16 sampled bits and `rd_update` pulses high for exactly one cycle.
- R6: In a write, `mdo_oe` is 0 for the first turnaround bit. It is 1 with `mdo`=0 for the second, and 1 with the write data for the data bits. A write produces no `rd_update`.
- R7: `read_start` or `write_start` is high for exactly one cycle, in the same cycle that `busy` rises. `busy` stays high through the last bit time and falls on a falling edge of `mdc`.
- R8: When several requests are pending at a frame boundary, write wins over read and read wins over scan. A request that arrives during a frame waits for that frame's end, and the next frame starts with no idle bit time.
- R9: While `cmd_scan` is held, scan frames follow each other with `busy` staying high. `not_valid` is 1 whenever `cmd_scan` is low and is cleared only when a scan frame completes. A completed one-shot read does not clear it.
- R10: At the end of each read or scan frame, `link_fail` takes the inverse of bit 2 of the received data (bit 2 = 1 means link up).
- R11: A one-cycle `mgmt_reset` aborts any frame. On the next cycle `busy`, `mdo_oe` and `mdc` are 0, and a later request runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_div | input | 8 | MDC divisor |
| no_preamble | input | 1 | Leave out the 32-bit preamble |
| mgmt_reset | input | 1 | Synchronous return to idle |
| phy_addr | input | 5 | PHY address for the next frame |
| reg_addr | input | 5 | Register address for the next frame |
| wr_data | input | 16 | Data for a write frame |
| cmd_scan | input | 1 | Level request for repeated polling |
| cmd_read | input | 1 | One-shot read request |
| cmd_write | input | 1 | One-shot write request |
| mdi | input | 1 | Serial data from the PHY |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Serial data to the PHY |
| mdo_oe | output | 1 | Drive enable for `mdo` |
| rd_data | output | 16 | Last data read from the PHY |
| rd_update | output | 1 | One-cycle strobe when `rd_data` is new |
| read_start | output | 1 | One-cycle pulse when a read frame begins |
| write_start | output | 1 | One-cycle pulse when a write frame begins |
| busy | output | 1 | A frame is in progress |
| not_valid | output | 1 | Scan data not yet refreshed |
| link_fail | output | 1 | Inverse of the link bit in the last read data |

## Verification
The assertions take for granted that a host drops a one-shot request once its start pulse has been seen, before the next frame boundary. They also assume `clk_div` and `no_preamble` change only while `busy` is low, and that `rst` is high from time zero. The stimulus follows these rules. Random operations change the divisor and the preamble option only between frames. Each request is cleared on the sample right after its start pulse. `mgmt_reset` is used only as a single-cycle pulse, which is the case the guards on the edge-alignment properties expect.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W    = 8,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int PRE_LEN  = 32,
  parameter int LINK_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              no_preamble,
  input  logic              mgmt_reset,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cmd_scan,
  input  logic              cmd_read,
  input  logic              cmd_write,
  input  logic              mdi,
  output logic              mdc,
  output logic              mdo,
  output logic              mdo_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_update,
  output logic              read_start,
  output logic              write_start,
  output logic              busy,
  output logic              not_valid,
  output logic              link_fail
);

  localparam int FL  = PRE_LEN + 6 + 2 * ADDR_W + DATA_W;
  localparam int CW  = $clog2(FL);
  localparam int HDR = FL - DATA_W - 2;

  typedef enum logic [1:0] {OP_SCAN, OP_READ, OP_WRITE} op_e;

  logic [DIV_W-1:0]  div_cnt, half;
  logic              tick, rise_ev, fall_ev, pending, data_phase;
  op_e               op, op_new;
  logic [FL-1:0]     sh, oe_sh, fr_new, oe_new;
  logic [CW-1:0]     left, len_new;
  logic [DATA_W-1:0] rx_sh, rx_next;

  assign half       = (clk_div[DIV_W-1:1] == '0) ? DIV_W'(1) : {1'b0, clk_div[DIV_W-1:1]};
  assign tick       = div_cnt >= half - DIV_W'(1);
  assign rise_ev    = tick & ~mdc;
  assign fall_ev    = tick & mdc;
  assign pending    = cmd_write | cmd_read | cmd_scan;
  assign op_new     = cmd_write ? OP_WRITE : (cmd_read ? OP_READ : OP_SCAN);
  assign rx_next    = {rx_sh[DATA_W-2:0], mdi};
  assign data_phase = busy && (op != OP_WRITE) && (left < CW'(DATA_W));

  always_comb begin
    fr_new  = {{PRE_LEN{1'b1}}, 2'b01, (cmd_write ? 2'b01 : 2'b10), phy_addr, reg_addr,
               2'b00, (cmd_write ? wr_data : {DATA_W{1'b0}})};
    oe_new  = {{HDR{1'b1}}, (cmd_write ? {2'b01, {DATA_W{1'b1}}} : {(DATA_W+2){1'b0}})};
    len_new = CW'(FL - 1);
    if (no_preamble) begin
      fr_new  = fr_new << PRE_LEN;
      oe_new  = oe_new << PRE_LEN;
      len_new = CW'(FL - PRE_LEN - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || mgmt_reset) begin
      div_cnt     <= '0;
      mdc         <= 1'b0;
      mdo         <= 1'b0;
      mdo_oe      <= 1'b0;
      busy        <= 1'b0;
      op          <= OP_SCAN;
      sh          <= '0;
      oe_sh       <= '0;
      left        <= '0;
      rx_sh       <= '0;
      rd_data     <= '0;
      rd_update   <= 1'b0;
      read_start  <= 1'b0;
      write_start <= 1'b0;
      not_valid   <= 1'b1;
      link_fail   <= 1'b0;
    end else begin
      rd_update   <= 1'b0;
      read_start  <= 1'b0;
      write_start <= 1'b0;
      if (tick) begin
        div_cnt <= '0;
        mdc     <= ~mdc;
      end else begin
        div_cnt <= div_cnt + DIV_W'(1);
      end
      if (fall_ev) begin
        if (busy && left != '0) begin
          mdo    <= sh[FL-1];
          mdo_oe <= oe_sh[FL-1];
          sh     <= sh << 1;
          oe_sh  <= oe_sh << 1;
          left   <= left - CW'(1);
        end else if (pending) begin
          busy        <= 1'b1;
          op          <= op_new;
          mdo         <= fr_new[FL-1];
          mdo_oe      <= oe_new[FL-1];
          sh          <= fr_new << 1;
          oe_sh       <= oe_new << 1;
          left        <= len_new;
          read_start  <= (op_new == OP_READ);
          write_start <= (op_new == OP_WRITE);
        end else begin
          busy   <= 1'b0;
          mdo    <= 1'b0;
          mdo_oe <= 1'b0;
        end
      end
      if (rise_ev && data_phase) begin
        rx_sh <= rx_next;
        if (left == '0) begin
          rd_data   <= rx_next;
          rd_update <= 1'b1;
          link_fail <= ~rx_next[LINK_BIT];
          if (op == OP_SCAN) not_valid <= 1'b0;
        end
      end
      if (!cmd_scan) not_valid <= 1'b1;
    end
  end

  p_start_busy_r7: assert property (@(posedge clk) disable iff (rst || mgmt_reset)
    (read_start || write_start) |-> busy);

  p_one_start_r8: assert property (@(posedge clk) disable iff (rst || mgmt_reset)
    $onehot0({read_start, write_start}));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst || mgmt_reset)
    !busy |-> !mdo_oe);

  p_update_pulse_r5: assert property (@(posedge clk) disable iff (rst || mgmt_reset)
    rd_update |=> !rd_update);

  p_mdo_on_fall_r3: assert property (@(posedge clk) disable iff (rst || mgmt_reset)
    ((!$stable(mdo) || !$stable(mdo_oe)) && !$past(mgmt_reset) && !$past(rst)) |-> $fell(mdc));

  p_busy_end_r7: assert property (@(posedge clk) disable iff (rst || mgmt_reset)
    ($fell(busy) && !$past(mgmt_reset) && !$past(rst)) |-> $fell(mdc));

  p_scan_off_r9: assert property (@(posedge clk) disable iff (rst)
    !cmd_scan |=> not_valid);

endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int CLK_T = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] clk_div = 8'd4;
  logic no_preamble = 1'b0, mgmt_reset = 1'b0;
  logic [4:0] phy_addr = '0, reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic cmd_scan = 1'b0, cmd_read = 1'b0, cmd_write = 1'b0, mdi = 1'b1;
  logic mdc, mdo, mdo_oe, rd_update, read_start, write_start, busy, not_valid, link_fail;
  logic [15:0] rd_data;

  always #(CLK_T/2) clk = ~clk;

  mdio_master u_mdio_master (
    .clk(clk), .rst(rst), .clk_div(clk_div), .no_preamble(no_preamble), .mgmt_reset(mgmt_reset),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data), .cmd_scan(cmd_scan),
    .cmd_read(cmd_read), .cmd_write(cmd_write), .mdi(mdi), .mdc(mdc), .mdo(mdo), .mdo_oe(mdo_oe),
    .rd_data(rd_data), .rd_update(rd_update), .read_start(read_start), .write_start(write_start),
    .busy(busy), .not_valid(not_valid), .link_fail(link_fail));

  int errs = 0, checks = 0, cyc = 0, posn = -1, nstart = 0, rise_cnt = 0, frames = 0;
  int upd_cnt = 0, last_rise = 0, period = 0;
  bit done = 1'b0;
  logic prev_mdc = 1'b0;
  logic [15:0] reply = '0;
  bit cap_oe [64];
  bit cap_mdo [64];

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!prev_mdc && mdc) begin
      if (busy && posn >= 0) begin
        cap_oe[posn]  = mdo_oe;
        cap_mdo[posn] = mdo;
        rise_cnt++;
      end
      period    = cyc - last_rise;
      last_rise = cyc;
    end
    if (prev_mdc && !mdc && busy) begin
      if (posn < 0 || posn == 63) begin
        posn = nstart;
        frames++;
      end else begin
        posn++;
      end
      mdi = (posn >= 48) ? reply[63-posn] : 1'b1;
    end
    if (!busy) posn = -1;
    if (rd_update) upd_cnt++;
    prev_mdc = mdc;
    cyc++;
  end

  function automatic int exp_period(int d);
    int h = d / 2;
    if (h == 0) h = 1;
    return 2 * h;
  endfunction

  function automatic bit [1:0] exp_bit(int p, bit wr, logic [4:0] pa, logic [4:0] ra, logic [15:0] wd);
    if (p < 32) return 2'b11;
    if (p == 32) return 2'b10;
    if (p == 33) return 2'b11;
    if (p == 34) return {1'b1, !wr};
    if (p == 35) return {1'b1, wr};
    if (p <= 40) return {1'b1, pa[40-p]};
    if (p <= 45) return {1'b1, ra[45-p]};
    if (p == 46) return 2'b00;
    if (p == 47) return wr ? 2'b10 : 2'b00;
    return wr ? {1'b1, wd[63-p]} : 2'b00;
  endfunction

  task automatic check_frame(bit wr, logic [4:0] pa, logic [4:0] ra, logic [15:0] wd);
    int bad = -1;
    bit [1:0] e;
    for (int p = nstart; p < 64; p++) begin
      e = exp_bit(p, wr, pa, ra, wd);
      if (bad < 0 && (cap_oe[p] != e[1] || (e[1] && cap_mdo[p] != e[0]))) bad = p;
    end
    if (bad < 0) chk(1'b1, "R3 frame bits", 0, 0);
    else begin
      e = exp_bit(bad, wr, pa, ra, wd);
      chk(1'b0, wr ? "R3/R6 write frame bit" : "R3/R5 read frame bit",
          {cap_oe[bad], cap_mdo[bad], 8'(bad)}, {e, 8'(bad)});
    end
    chk(rise_cnt == 64 - nstart, "R4 bit times per frame", rise_cnt, 64 - nstart);
  endtask

  task automatic do_op(bit wr, logic [4:0] pa, logic [4:0] ra, logic [15:0] wd, logic [15:0] rep);
    int u0;
    bit sw, sr, sb;
    @(negedge clk);
    phy_addr = pa; reg_addr = ra; wr_data = wd; reply = rep;
    rise_cnt = 0; u0 = upd_cnt;
    if (wr) cmd_write = 1'b1; else cmd_read = 1'b1;
    do @(negedge clk); while (!(write_start || read_start));
    sw = write_start; sr = read_start; sb = busy;
    cmd_write = 1'b0; cmd_read = 1'b0;
    chk(sw == wr && sr == !wr, "R7 start pulse kind", {sw, sr}, {wr, !wr});
    chk(sb, "R7 busy with start", sb, 1);
    @(negedge clk);
    chk(!write_start && !read_start, "R7 start lasts one cycle", {write_start, read_start}, 0);
    do @(negedge clk); while (busy);
    check_frame(wr, pa, ra, wd);
    if (wr) chk(upd_cnt == u0, "R6 no update on write", upd_cnt - u0, 0);
    else begin
      chk(upd_cnt == u0 + 1, "R5 one update strobe", upd_cnt - u0, 1);
      chk(rd_data == rep, "R5 read data", rd_data, rep);
      chk(link_fail == !rep[2], "R10 link fail after read", link_fail, !rep[2]);
    end
  endtask

  task automatic wait_update();
    do @(negedge clk); while (!rd_update);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int f0, gap;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(mdc == 0 && busy == 0 && mdo_oe == 0, "R1 reset idle outputs", {mdc, busy, mdo_oe}, 0);
    chk(not_valid == 1 && link_fail == 0, "R1 reset flags", {not_valid, link_fail}, 2'b10);
    chk(rd_data == 0 && rd_update == 0 && !read_start && !write_start, "R1 reset data", rd_data, 0);
    rst = 1'b0;

    foreach (clk_div[i]) ;
    for (int k = 0; k < 7; k++) begin
      int d;
      case (k) 0: d = 0; 1: d = 1; 2: d = 3; 3: d = 4; 4: d = 7; 5: d = 10; default: d = 255; endcase
      @(negedge clk); clk_div = 8'(d);
      repeat (3 * exp_period(d) + 20) @(negedge clk);
      chk(period == exp_period(d), "R2 mdc period", period, exp_period(d));
    end

    clk_div = 8'd4;
    repeat (20) @(negedge clk);
    do_op(1'b1, 5'h15, 5'h0a, 16'hA5C3, 16'h0);
    do_op(1'b0, 5'h01, 5'h1f, 16'h0, 16'h8004);
    do_op(1'b0, 5'h1e, 5'h00, 16'h0, 16'h7FFB);
    @(negedge clk); no_preamble = 1'b1; nstart = 32;
    do_op(1'b1, 5'h00, 5'h11, 16'hFFFF, 16'h0);
    do_op(1'b0, 5'h1f, 5'h05, 16'h0, 16'h1234);
    @(negedge clk); no_preamble = 1'b0; nstart = 0;

    // R8: all three pending at once
    @(negedge clk);
    reply = 16'h0004; f0 = frames;
    cmd_write = 1'b1; cmd_read = 1'b1; cmd_scan = 1'b1;
    do @(negedge clk); while (!(write_start || read_start));
    chk(write_start && !read_start, "R8 write first", {write_start, read_start}, 2'b10);
    cmd_write = 1'b0;
    do @(negedge clk); while (!(write_start || read_start));
    chk(read_start, "R8 read second", read_start, 1);
    cmd_read = 1'b0;
    @(negedge clk);
    chk(frames == f0 + 2, "R8 read follows write directly", frames - f0, 2);
    wait_update();
    @(negedge clk);
    chk(not_valid == 1, "R9 read leaves not_valid", not_valid, 1);
    wait_update();
    @(negedge clk);
    chk(not_valid == 0, "R9 scan clears not_valid", not_valid, 0);
    cmd_scan = 1'b0;
    @(negedge clk);
    chk(not_valid == 1, "R9 scan off sets not_valid", not_valid, 1);
    do @(negedge clk); while (busy);

    // R9/R10: scan back to back
    @(negedge clk);
    reply = 16'h0000; cmd_scan = 1'b1;
    @(negedge clk);
    chk(not_valid == 1, "R9 not_valid before first scan", not_valid, 1);
    wait_update();
    chk(link_fail == 1 && rd_data == 16'h0000, "R10 link down", {link_fail, rd_data}, {1'b1, 16'h0});
    chk(not_valid == 0, "R9 first scan frame done", not_valid, 0);
    reply = 16'hFFFF; gap = 0;
    do begin @(negedge clk); if (!busy) gap++; end while (!rd_update);
    chk(gap == 0, "R9 scan frames back to back", gap, 0);
    chk(link_fail == 0 && rd_data == 16'hFFFF, "R10 link up", {link_fail, rd_data}, {1'b0, 16'hFFFF});
    cmd_scan = 1'b0;
    do @(negedge clk); while (busy);

    // R11: abort
    @(negedge clk);
    cmd_read = 1'b1;
    do @(negedge clk); while (!read_start);
    cmd_read = 1'b0;
    repeat (100) @(negedge clk);
    mgmt_reset = 1'b1;
    @(negedge clk);
    mgmt_reset = 1'b0;
    chk(!busy && !mdo_oe && !mdc, "R11 abort to idle", {busy, mdo_oe, mdc}, 0);
    repeat (20) @(negedge clk);
    chk(!busy, "R11 stays idle", busy, 0);
    do_op(1'b0, 5'h0c, 5'h03, 16'h0, 16'hBEEF);

    for (int n = 0; n < 20; n++) begin
      bit np;
      @(negedge clk);
      clk_div = 8'(2 + $urandom % 8);
      np = 1'($urandom % 2);
      no_preamble = np; nstart = np ? 32 : 0;
      do_op(1'($urandom % 2), 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule